// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits on the write side of a 16-bit parallel NOR-flash command port. It watches every bus write, each an address and a data word, and follows the keyed write sequences that the port defines. Each command is guarded by a two-write unlock key. The low byte of the data word carries the command code. Only the low `CMP_W` address bits are compared while the block decodes a sequence. When a sequence completes, the block raises a one-cycle pulse on the matching output: reset, signature entry, program (with the target address and data word captured) or chip erase. Any write that breaks a sequence sends the block back to the idle state and to array-read mode.

The block also sets the read mode. While signature mode is active, the block looks up a code from two read-select bits, with one cycle of latency. Array-read mode and signature mode each persist through any number of idle cycles, until the next write that the block accepts.

An external `busy` input marks that a program or erase is running. While `busy` is high the block ignores every write except a reset. A reset issued while `busy` is high starts a lockout of `LOCK_CYCLES` clock cycles. During the lockout the block again accepts only resets.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and after it rises, `sig_mode`, `hold_off`, `sig_data` and all four pulse outputs are 0, and the decoder is idle.
- R2: The key writes and the command writes compare only address bits [CMP_W-1:0] (default 11). The first key is data AAh at 555h, the second key is 55h at 2AAh, and the command writes go to 555h. Higher address bits are ignored, and a key at any other low address does not unlock the decoder.
- R3: A write whose low byte is F0h, at any address and in any state except the program-data slot, produces `rst_pulse` one cycle later, clears `sig_mode` and returns the decoder to idle. This holds for a lone write and also after the unlock keys or in the middle of the erase sequence.
- R4: The keys followed by 90h at 555h produce `asel_pulse` and set `sig_mode`. `sig_mode` stays 1 through idle cycles until the next accepted write.
- R5: One cycle after `sig_sel` is applied in signature mode, `sig_data` reads as follows: `sig_sel`=00 gives 0020h, 01 gives `DEV_CODE`, and 10 or 11 give 0. In array mode `sig_data` is 0.
- R6: The keys, then A0h at 555h, then one more write produce `prog_pulse`, with `prog_addr` and `prog_data` equal to that fourth write's full address and data. The fourth write is taken as data even when its low byte is F0h.
- R7: The keys, 80h at 555h, the keys again, then 10h at 555h produce `erase_pulse` on the sixth write.
- R8: A write that does not match the next step of a sequence returns the decoder to idle and array mode. A command byte that follows it produces no pulse.
- R9: While `busy` is 1, writes other than F0h are ignored and leave the decoder state and `sig_mode` unchanged.
- R10: A reset write while `busy` is 1 sets `hold_off` for exactly `LOCK_CYCLES` cycles. During that window, writes other than F0h are ignored.
- R11: The pulse outputs last one cycle each, at most one of them is high at a time, and each completed sequence yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low byte is the command code |
| busy | input | 1 | A program or erase is in progress |
| sig_sel | input | 2 | Address bits A1:A0 for signature reads |
| rst_pulse | output | 1 | Reset command decoded |
| asel_pulse | output | 1 | Signature entry decoded |
| prog_pulse | output | 1 | Program command decoded |
| erase_pulse | output | 1 | Chip erase decoded |
| prog_addr | output | ADDR_W | Captured program address |
| prog_data | output | DATA_W | Captured program data |
| sig_mode | output | 1 | 1 = signature read mode, 0 = array read |
| sig_data | output | DATA_W | Signature code for `sig_sel` |
| hold_off | output | 1 | Lockout after a reset issued while busy |

## Verification
The assertions check several properties on every cycle: the pulses are mutually exclusive, the captured program fields match the write before them, an erase pulse follows a 10h write at 555h, no command pulse follows a write made while busy or in lockout, signature mode starts only with a signature pulse, and the lockout starts only on a load. Only the bench's scenarios show that each whole sequence yields its single pulse in the right cycle. The same holds for broken sequences, ignored address bits and ignored busy writes, which must leave the mode untouched. The bench scenarios also cover the exact length of the lockout and the signature codes for each select value.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PDATA,
        ST_ERS0,
        ST_ERS1,
        ST_ERS2
    } fcd_state_e;

    localparam logic [7:0]  KEY1_DATA  = 8'hAA;
    localparam logic [7:0]  KEY2_DATA  = 8'h55;
    localparam logic [10:0] KEY1_ADDR  = 11'h555;
    localparam logic [10:0] KEY2_ADDR  = 11'h2AA;
    localparam logic [7:0]  OP_RESET   = 8'hF0;
    localparam logic [7:0]  OP_SIG     = 8'h90;
    localparam logic [7:0]  OP_PROG    = 8'hA0;
    localparam logic [7:0]  OP_ESETUP  = 8'h80;
    localparam logic [7:0]  OP_ECHIP   = 8'h10;
    localparam logic [7:0]  MFR_ID     = 8'h20;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
    import flash_cmd_pkg::*;
#(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] addr_i,
    input  logic [7:0]       byte_i,
    output logic             at_a1_o,
    output logic             key1_o,
    output logic             key2_o,
    output logic             op_reset_o,
    output logic             op_sig_o,
    output logic             op_prog_o,
    output logic             op_esetup_o,
    output logic             op_echip_o
);
    localparam logic [CMP_W-1:0] A1 = CMP_W'(KEY1_ADDR);
    localparam logic [CMP_W-1:0] A2 = CMP_W'(KEY2_ADDR);

    logic at_a1, at_a2;

    always_comb begin
        at_a1       = (addr_i == A1);
        at_a2       = (addr_i == A2);
        at_a1_o     = at_a1;
        key1_o      = at_a1 && (byte_i == KEY1_DATA);
        key2_o      = at_a2 && (byte_i == KEY2_DATA);
        op_reset_o  = (byte_i == OP_RESET);
        op_sig_o    = at_a1 && (byte_i == OP_SIG);
        op_prog_o   = at_a1 && (byte_i == OP_PROG);
        op_esetup_o = at_a1 && (byte_i == OP_ESETUP);
        op_echip_o  = at_a1 && (byte_i == OP_ECHIP);
    end
endmodule

// File: rtl/fcd_lockout.sv
module fcd_lockout #(
    parameter int LOCK_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic hold_o
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             hold_d, hold_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        hold_d = (cnt_d != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
        end
    end

    assign hold_o = hold_q;

    // R10
    lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(load_i));
endmodule

// File: rtl/fcd_sig_port.sv
module fcd_sig_port
    import flash_cmd_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h0033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_mode_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = '0;
        if (sig_mode_i) begin
            case (sel_i)
                2'b00:   data_d = DATA_W'(MFR_ID);
                2'b01:   data_d = DEV_CODE;
                default: data_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

    // R5
    sig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sig_mode_i) |-> (data_q == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W      = 17,
    parameter int                DATA_W      = 16,
    parameter int                CMP_W       = 11,
    parameter int                LOCK_CYCLES = 500,
    parameter logic [DATA_W-1:0] DEV_CODE    = 16'h0033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [1:0]        sig_sel,
    output logic              rst_pulse,
    output logic              asel_pulse,
    output logic              prog_pulse,
    output logic              erase_pulse,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              sig_mode,
    output logic [DATA_W-1:0] sig_data,
    output logic              hold_off
);
    typedef struct packed {
        fcd_state_e        st;
        logic              sig;
        logic              rst_p;
        logic              asel_p;
        logic              prog_p;
        logic              erase_p;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
    } fcd_regs_t;

    fcd_regs_t r_d, r_q;

    logic at_a1, key1, key2, op_reset, op_sig, op_prog, op_esetup, op_echip;
    logic accept, do_reset, lock_load, hold;

    fcd_match #(.CMP_W(CMP_W)) u_match (
        .addr_i      (wr_addr[CMP_W-1:0]),
        .byte_i      (wr_data[7:0]),
        .at_a1_o     (at_a1),
        .key1_o      (key1),
        .key2_o      (key2),
        .op_reset_o  (op_reset),
        .op_sig_o    (op_sig),
        .op_prog_o   (op_prog),
        .op_esetup_o (op_esetup),
        .op_echip_o  (op_echip)
    );

    fcd_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (lock_load),
        .hold_o (hold)
    );

    fcd_sig_port #(.DATA_W(DATA_W), .DEV_CODE(DEV_CODE)) u_sig (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_mode_i (r_q.sig),
        .sel_i      (sig_sel),
        .data_o     (sig_data)
    );

    always_comb begin
        accept    = wr_en && !busy && !hold;
        do_reset  = wr_en && op_reset && !((r_q.st == ST_PDATA) && accept);
        lock_load = do_reset && busy;

        r_d         = r_q;
        r_d.rst_p   = 1'b0;
        r_d.asel_p  = 1'b0;
        r_d.prog_p  = 1'b0;
        r_d.erase_p = 1'b0;

        if (do_reset) begin
            r_d.st    = ST_IDLE;
            r_d.sig   = 1'b0;
            r_d.rst_p = 1'b1;
        end else if (accept) begin
            r_d.st  = ST_IDLE;
            r_d.sig = 1'b0;
            case (r_q.st)
                ST_IDLE: if (key1) r_d.st = ST_KEY1;
                ST_KEY1: if (key2) r_d.st = ST_KEY2;
                ST_KEY2: begin
                    if (op_sig) begin
                        r_d.asel_p = 1'b1;
                        r_d.sig    = 1'b1;
                    end else if (op_prog) begin
                        r_d.st = ST_PDATA;
                    end else if (op_esetup) begin
                        r_d.st = ST_ERS0;
                    end
                end
                ST_PDATA: begin
                    r_d.prog_p = 1'b1;
                    r_d.paddr  = wr_addr;
                    r_d.pdata  = wr_data;
                end
                ST_ERS0: if (key1) r_d.st = ST_ERS1;
                ST_ERS1: if (key2) r_d.st = ST_ERS2;
                ST_ERS2: if (op_echip) r_d.erase_p = 1'b1;
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.sig     <= 1'b0;
            r_q.rst_p   <= 1'b0;
            r_q.asel_p  <= 1'b0;
            r_q.prog_p  <= 1'b0;
            r_q.erase_p <= 1'b0;
            r_q.paddr   <= '0;
            r_q.pdata   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rst_pulse   = r_q.rst_p;
    assign asel_pulse  = r_q.asel_p;
    assign prog_pulse  = r_q.prog_p;
    assign erase_pulse = r_q.erase_p;
    assign prog_addr   = r_q.paddr;
    assign prog_data   = r_q.pdata;
    assign sig_mode    = r_q.sig;
    assign hold_off    = hold;

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_pulse, asel_pulse, prog_pulse, erase_pulse}));

    // R6
    prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> ($past(wr_en) && prog_addr == $past(wr_addr)
                        && prog_data == $past(wr_data)));

    // R7
    erase_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |-> ($past(wr_en) && $past(wr_data[7:0]) == OP_ECHIP
                         && $past(wr_addr[CMP_W-1:0]) == CMP_W'(KEY1_ADDR)));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asel_pulse || prog_pulse || erase_pulse) |-> (!$past(busy) && !$past(hold_off)));

    // R4
    sig_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_mode) |-> asel_pulse);

    // R3
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (!sig_mode && $past(wr_en) && $past(wr_data[7:0]) == OP_RESET));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 16;
    localparam int LOCK = 16;
    localparam logic [DW-1:0] DEVC = 16'h0033;

    localparam logic [2:0] K_RST = 3'd1, K_ASEL = 3'd2, K_PROG = 3'd3, K_ERASE = 3'd4;

    typedef struct packed {
        logic [2:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic [1:0]    sig_sel = 2'b00;
    logic          rst_pulse, asel_pulse, prog_pulse, erase_pulse;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;
    logic          sig_mode, hold_off;
    logic [DW-1:0] sig_data;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .CMP_W(11),
                        .LOCK_CYCLES(LOCK), .DEV_CODE(DEVC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .sig_sel(sig_sel),
        .rst_pulse(rst_pulse), .asel_pulse(asel_pulse), .prog_pulse(prog_pulse),
        .erase_pulse(erase_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
        .sig_mode(sig_mode), .sig_data(sig_data), .hold_off(hold_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_item(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d;
        sb.push_back(e);
    endtask

    // driver: one write, starting and ending on a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(17'h00555, 16'h00AA);
        wr(17'h002AA, 16'h0055);
    endtask

    // monitor: pops one expected item for every pulse seen
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic [2:0] k;
                k = rst_pulse ? K_RST : asel_pulse ? K_ASEL :
                    prog_pulse ? K_PROG : erase_pulse ? K_ERASE : 3'd0;
                if (k != 3'd0) begin
                    if (sb.size() == 0) begin
                        chk("R11 unexpected pulse", 32'(k), 32'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        case (e.kind)
                            K_RST:   chk("R3 reset pulse", 32'(k), 32'(e.kind));
                            K_ASEL:  chk("R4 signature pulse", 32'(k), 32'(e.kind));
                            K_ERASE: chk("R7 erase pulse", 32'(k), 32'(e.kind));
                            default: begin
                                chk("R6 program pulse", 32'(k), 32'(e.kind));
                                chk("R6 program address", 32'(prog_addr), 32'(e.addr));
                                chk("R6 program data", 32'(prog_data), 32'(e.data));
                            end
                        endcase
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sig_mode", 32'(sig_mode), 0);
        chk("R1 hold_off", 32'(hold_off), 0);
        chk("R1 pulses", 32'({rst_pulse, asel_pulse, prog_pulse, erase_pulse}), 0);
        chk("R1 sig_data", 32'(sig_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 lone reset write at an arbitrary address
        expect_item(K_RST, '0, '0);
        wr(17'h1ABCD, 16'h00F0);

        // R4 signature entry and persistence
        expect_item(K_ASEL, '0, '0);
        unlock();
        wr(17'h00555, 16'h0090);
        chk("R4 sig_mode set", 32'(sig_mode), 1);
        // R5 signature codes
        sig_sel = 2'b00; @(negedge clk);
        chk("R5 manufacturer code", 32'(sig_data), 32'h20);
        sig_sel = 2'b01; @(negedge clk);
        chk("R5 device code", 32'(sig_data), 32'(DEVC));
        sig_sel = 2'b10; @(negedge clk);
        chk("R5 other select", 32'(sig_data), 0);
        repeat (5) @(negedge clk);
        chk("R4 sig_mode persists", 32'(sig_mode), 1);

        // R9 writes while busy are ignored
        busy = 1'b1;
        unlock();
        wr(17'h00555, 16'h00A0);
        wr(17'h00123, 16'h0BEE);
        busy = 1'b0;
        chk("R9 busy writes ignored", 32'(sig_mode), 1);

        // R3 reset after the keys clears signature mode
        expect_item(K_RST, '0, '0);
        unlock();
        wr(17'h00000, 16'h00F0);
        chk("R3 sig_mode cleared", 32'(sig_mode), 0);
        sig_sel = 2'b00; @(negedge clk);
        chk("R5 array mode reads zero", 32'(sig_data), 0);

        // R6 program, including an F0h data word
        expect_item(K_PROG, 17'h1F00F, 16'hA5C3);
        unlock();
        wr(17'h00555, 16'h00A0);
        wr(17'h1F00F, 16'hA5C3);
        expect_item(K_PROG, 17'h00042, 16'h00F0);
        unlock();
        wr(17'h00555, 16'h00A0);
        wr(17'h00042, 16'h00F0);

        // R2 high address bits ignored
        expect_item(K_ASEL, '0, '0);
        wr(17'h1F555, 16'h00AA);
        wr(17'h0A2AA, 16'h0055);
        wr(17'h10555, 16'h0090);
        chk("R2 high bits ignored", 32'(sig_mode), 1);
        expect_item(K_RST, '0, '0);
        wr(17'h00000, 16'h00F0);
        // R2 wrong low address does not unlock
        wr(17'h00455, 16'h00AA);
        wr(17'h002AA, 16'h0055);
        wr(17'h00555, 16'h0090);
        chk("R2 wrong low address", 32'(sig_mode), 0);

        // R7 chip erase
        expect_item(K_ERASE, '0, '0);
        unlock();
        wr(17'h00555, 16'h0080);
        unlock();
        wr(17'h00555, 16'h0010);
        // R8 wrong final byte, then 10h alone
        unlock();
        wr(17'h00555, 16'h0080);
        unlock();
        wr(17'h00555, 16'h0030);
        wr(17'h00555, 16'h0010);
        // R3 reset in the middle of erase
        expect_item(K_RST, '0, '0);
        unlock();
        wr(17'h00555, 16'h0080);
        wr(17'h00555, 16'h00F0);

        // R8 broken second key, then a command byte
        wr(17'h00555, 16'h00AA);
        wr(17'h002AA, 16'h0012);
        wr(17'h00555, 16'h0090);
        chk("R8 broken key no signature", 32'(sig_mode), 0);
        unlock();
        wr(17'h00555, 16'h0077);
        wr(17'h00555, 16'h00A0);
        wr(17'h00100, 16'h1234);
        @(negedge clk);
        chk("R8 no stray pulses", 32'(sb.size()), 0);

        // R10 lockout after a reset while busy
        busy = 1'b1;
        expect_item(K_RST, '0, '0);
        wr(17'h00000, 16'h00F0);
        busy = 1'b0;
        chk("R10 hold_off set", 32'(hold_off), 1);
        unlock();
        wr(17'h00555, 16'h0090);
        chk("R10 writes ignored in lockout", 32'(sig_mode), 0);
        repeat (LOCK - 4) @(negedge clk);
        chk("R10 hold_off last cycle", 32'(hold_off), 1);
        @(negedge clk);
        chk("R10 hold_off released", 32'(hold_off), 0);
        expect_item(K_ASEL, '0, '0);
        unlock();
        wr(17'h00555, 16'h0090);
        chk("R10 accepted after lockout", 32'(sig_mode), 1);
        expect_item(K_RST, '0, '0);
        wr(17'h00000, 16'h00F0);

        repeat (4) @(negedge clk);
        // R11 every expected pulse appeared exactly once
        chk("R11 scoreboard drained", 32'(sb.size()), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule